// File: doc/BRIEF.md
# Write-Only Two-Wire Control Slave

This block is the serial control port of a mixed-signal control chip. It watches the two lines of an I2C bus, SCL and SDA, through synchronisers clocked by a system clock that runs far faster than the bus (the bus clock tops out at 400 kHz). It recognises start and stop conditions and assembles bytes as they arrive, most significant bit first. It also compares the first byte of each transfer against its own 7-bit address, where one strap pin sets the lowest address bit.

When the address matches and the direction bit asks for a write, the block acknowledges by pulling SDA low through an open-drain enable. Every data byte that follows is acknowledged as well and is passed to a downstream register decoder on a one-cycle strobe. There is no limit on the number of data bytes, and the transfer runs until a stop. The bus gives no way to hold off the master without clock stretching, so the output stream has valid but no ready. The decoder must take every strobe in the cycle it appears, and strobes are always at least a full bus byte apart.

Top module: `i2c_wr_slave`

## Requirements
- R1: After reset, `sda_pull_o` is 0 and `byte_vld_o` is 0.
- R2: The 7-bit slave address is binary 001100 followed by the value of `addr_strap_i`. On the wire, the address byte is that address in bits 7..1 and the direction bit in bit 0, where 0 means write. With the strap high the address byte is 0x32, and with the strap low it is 0x30.
- R3: After a matching write address byte, and after each data byte that follows it, `sda_pull_o` is 1 throughout the high phase of the ninth SCL clock. It rises only after the SCL fall that ends the eighth bit and clears after the SCL fall that ends the ninth clock. It is 0 during every data-bit high phase.
- R4: If the address byte does not match, or has direction bit 1, no acknowledge is given. The bus is then ignored until the next start or stop: no acknowledge and no strobe occur for any later byte.
- R5: Each complete data byte produces exactly one `byte_vld_o` pulse, one clock long, with `byte_o` holding the 8 received bits (the first bit on the wire in bit 7). Pulses come in bus order.
- R6: A start is SDA falling while SCL is high, and a stop is SDA rising while SCL is high. A stop ends the transfer and releases `sda_pull_o`. Bytes clocked after a stop, without a new start, cause no acknowledge and no strobe.
- R7: A repeated start in the middle of a transfer returns the block to the address phase. The next byte is treated as an address.
- R8: A stop that arrives before all 8 bits of a data byte have been clocked discards the partial byte, and no strobe is produced for it.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock, much faster than SCL |
| rst_n | input | 1 | Asynchronous active-low reset |
| scl_i | input | 1 | Bus clock line as seen at the pad |
| sda_i | input | 1 | Bus data line as seen at the pad |
| addr_strap_i | input | 1 | Strap that sets address bit 0 |
| sda_pull_o | output | 1 | 1 drives SDA low (open-drain enable) |
| byte_vld_o | output | 1 | One-cycle strobe: `byte_o` holds a new data byte |
| byte_o | output | 8 | Received data byte |

## Verification
The bench drives both strap settings with addresses that match and addresses that do not, including the address with the read bit set. A design that compared only six bits, or ignored the direction bit, would acknowledge there and stream bogus bytes. It ends a transfer with a stop in the middle of a byte: a block that flushed partial bytes would emit an extra strobe, and one that failed to clear its bit count would misalign the next transfer. It also issues a repeated start after a data byte. A design that stayed in the data phase would deliver the second address as data and fail to acknowledge it as an address. Data bytes of all zeros and all ones, sent back to back, expose acknowledge timing that is released too late (it would corrupt the next bit's high phase) or asserted too early (it would clash with bit 8).

// File: rtl/i2cw_pkg.sv
package i2cw_pkg;
  localparam int BYTE_W = 8;
  localparam int ADDR_W = 7;

  typedef enum logic [1:0] {
    PH_IDLE = 2'd0,
    PH_ADDR = 2'd1,
    PH_DATA = 2'd2,
    PH_SKIP = 2'd3
  } phase_t;
endpackage

// File: rtl/i2cw_sync.sv
module i2cw_sync #(
  parameter int  STAGES  = 2,
  parameter logic RST_VAL = 1'b1
) (
  input  logic clk,
  input  logic rst_n,
  input  logic d_i,
  output logic q_o
);
  logic [STAGES-1:0] chain;

  generate
    for (genvar g = 0; g < STAGES; g++) begin : g_stage
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) chain[g] <= RST_VAL;
        else if (g == 0) chain[g] <= d_i;
        else chain[g] <= chain[(g == 0) ? 0 : g-1];
      end
    end
  endgenerate

  assign q_o = chain[STAGES-1];
endmodule

// File: rtl/i2cw_bus_events.sv
module i2cw_bus_events (
  input  logic clk,
  input  logic rst_n,
  input  logic scl_s,
  input  logic sda_s,
  output logic scl_rise_o,
  output logic scl_fall_o,
  output logic start_o,
  output logic stop_o,
  output logic sda_bit_o
);
  logic scl_q, sda_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      scl_q <= 1'b1;
      sda_q <= 1'b1;
    end else begin
      scl_q <= scl_s;
      sda_q <= sda_s;
    end
  end

  assign scl_rise_o = scl_s & ~scl_q;
  assign scl_fall_o = ~scl_s & scl_q;
  assign start_o    = scl_s & scl_q & sda_q & ~sda_s;
  assign stop_o     = scl_s & scl_q & ~sda_q & sda_s;
  assign sda_bit_o  = sda_s;
endmodule

// File: rtl/i2cw_rx_fsm.sv
module i2cw_rx_fsm
  import i2cw_pkg::*;
#(
  parameter logic [ADDR_W-2:0] ADDR_HI = 6'b001100
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              rise_i,
  input  logic              fall_i,
  input  logic              start_i,
  input  logic              stop_i,
  input  logic              sda_bit_i,
  input  logic              strap_i,
  output logic              ack_oe_o,
  output logic              vld_o,
  output logic [BYTE_W-1:0] data_o
);
  localparam int CNT_W = $clog2(BYTE_W + 1);
  localparam logic [CNT_W-1:0] FULL = CNT_W'(BYTE_W);

  phase_t            ph;
  logic [CNT_W-1:0]  bitcnt;
  logic [BYTE_W-1:0] shreg;
  logic              byte_done, addr_ok, active;
  logic [ADDR_W-1:0] my_addr;

  assign byte_done = (bitcnt == FULL);
  assign my_addr   = {ADDR_HI, strap_i};
  assign addr_ok   = (shreg[BYTE_W-1:1] == my_addr) && !shreg[0];
  assign active    = (ph == PH_ADDR) || (ph == PH_DATA);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ph       <= PH_IDLE;
      bitcnt   <= '0;
      shreg    <= '0;
      ack_oe_o <= 1'b0;
      vld_o    <= 1'b0;
      data_o   <= '0;
    end else begin
      vld_o <= 1'b0;
      if (start_i) begin
        ph       <= PH_ADDR;
        bitcnt   <= '0;
        ack_oe_o <= 1'b0;
      end else if (stop_i) begin
        ph       <= PH_IDLE;
        bitcnt   <= '0;
        ack_oe_o <= 1'b0;
      end else if (active) begin
        if (rise_i && !byte_done) begin
          shreg  <= {shreg[BYTE_W-2:0], sda_bit_i};
          bitcnt <= bitcnt + 1'b1;
        end else if (fall_i && byte_done) begin
          if (!ack_oe_o) begin
            if (ph == PH_ADDR) begin
              if (addr_ok) ack_oe_o <= 1'b1;
              else begin
                ph     <= PH_SKIP;
                bitcnt <= '0;
              end
            end else begin
              ack_oe_o <= 1'b1;
              vld_o    <= 1'b1;
              data_o   <= shreg;
            end
          end else begin
            ack_oe_o <= 1'b0;
            bitcnt   <= '0;
            ph       <= PH_DATA;
          end
        end
      end
    end
  end

  // R5: strobe lasts one clock
  p_vld_pulse_r5: assert property (@(posedge clk) disable iff (!rst_n)
    vld_o |=> !vld_o);
  // R5: strobes only in the data phase
  p_vld_data_r5: assert property (@(posedge clk) disable iff (!rst_n)
    vld_o |-> ph == PH_DATA);
  // R6: stop releases the line and idles
  p_stop_release_r6: assert property (@(posedge clk) disable iff (!rst_n)
    stop_i && !start_i |=> !ack_oe_o && ph == PH_IDLE);
  // R7: any start leads to the address phase
  p_start_addr_r7: assert property (@(posedge clk) disable iff (!rst_n)
    start_i |=> ph == PH_ADDR && !ack_oe_o);
  // R3: acknowledge begins only on an SCL fall
  p_ack_on_fall_r3: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(ack_oe_o) |-> $past(fall_i));
  // R3: acknowledge ends only on SCL fall, start or stop
  p_ack_release_r3: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(ack_oe_o) |-> $past(fall_i || start_i || stop_i));
  // R4: ignored transfers never acknowledge
  p_skip_quiet_r4: assert property (@(posedge clk) disable iff (!rst_n)
    ph == PH_SKIP |-> !ack_oe_o && !vld_o);
endmodule

// File: rtl/i2c_wr_slave.sv
module i2c_wr_slave
  import i2cw_pkg::*;
#(
  parameter int                SYNC_STAGES = 2,
  parameter logic [ADDR_W-2:0] ADDR_HI     = 6'b001100
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              scl_i,
  input  logic              sda_i,
  input  logic              addr_strap_i,
  output logic              sda_pull_o,
  output logic              byte_vld_o,
  output logic [BYTE_W-1:0] byte_o
);
  logic scl_s, sda_s, strap_s;
  logic rise, fall, start_c, stop_c, sbit;

  i2cw_sync #(.STAGES(SYNC_STAGES), .RST_VAL(1'b1)) u_sync_scl (
    .clk(clk), .rst_n(rst_n), .d_i(scl_i), .q_o(scl_s));
  i2cw_sync #(.STAGES(SYNC_STAGES), .RST_VAL(1'b1)) u_sync_sda (
    .clk(clk), .rst_n(rst_n), .d_i(sda_i), .q_o(sda_s));
  i2cw_sync #(.STAGES(SYNC_STAGES), .RST_VAL(1'b1)) u_sync_strap (
    .clk(clk), .rst_n(rst_n), .d_i(addr_strap_i), .q_o(strap_s));

  i2cw_bus_events u_events (
    .clk(clk), .rst_n(rst_n), .scl_s(scl_s), .sda_s(sda_s),
    .scl_rise_o(rise), .scl_fall_o(fall), .start_o(start_c),
    .stop_o(stop_c), .sda_bit_o(sbit));

  i2cw_rx_fsm #(.ADDR_HI(ADDR_HI)) u_fsm (
    .clk(clk), .rst_n(rst_n), .rise_i(rise), .fall_i(fall),
    .start_i(start_c), .stop_i(stop_c), .sda_bit_i(sbit),
    .strap_i(strap_s), .ack_oe_o(sda_pull_o), .vld_o(byte_vld_o),
    .data_o(byte_o));
endmodule

// File: tb/i2c_wr_slave_tb.sv
module i2c_wr_slave_tb;
  localparam int Q = 12;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic scl_m = 1'b1, sda_m = 1'b1, strap = 1'b1;
  logic sda_line;
  logic sda_pull, vld;
  logic [7:0] dout;
  int checks = 0, fails = 0;
  logic [7:0] expq[$];
  logic vld_q = 1'b0;

  always #2 clk = ~clk;
  assign sda_line = sda_m & ~sda_pull;

  i2c_wr_slave u_dut (
    .clk(clk), .rst_n(rst_n), .scl_i(scl_m), .sda_i(sda_line),
    .addr_strap_i(strap), .sda_pull_o(sda_pull), .byte_vld_o(vld),
    .byte_o(dout));

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  // Reference scoreboard: compare strobes against the expected byte queue every clock
  always @(negedge clk) begin
    if (rst_n) begin
      if (vld) begin
        if (expq.size() == 0) chk(1'b0, "R5/R4 unexpected strobe", dout, 0);
        else begin
          logic [7:0] e;
          e = expq.pop_front();
          chk(dout == e, "R5 data byte", dout, e);
        end
        if (vld_q) chk(1'b0, "R5 strobe longer than one clock", 1, 0);
      end
      vld_q <= vld;
    end
  end

  task automatic wt(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic bit_clk(input logic b, input logic exp_p, input string req);
    sda_m = b; wt(Q);
    scl_m = 1'b1; wt(Q);
    chk(sda_pull == exp_p, req, sda_pull, exp_p);
    wt(Q);
    scl_m = 1'b0; wt(Q);
  endtask

  task automatic send_byte(input logic [7:0] v, input logic exp_ack, input string req);
    for (int i = 7; i >= 0; i--) bit_clk(v[i], 1'b0, "R3 no pull during data bit");
    bit_clk(1'b1, exp_ack, req);
  endtask

  task automatic start_c();
    sda_m = 1'b1; wt(Q); scl_m = 1'b1; wt(Q);
    sda_m = 1'b0; wt(Q); scl_m = 1'b0; wt(Q);
  endtask

  task automatic stop_c();
    sda_m = 1'b0; wt(Q); scl_m = 1'b1; wt(Q);
    sda_m = 1'b1; wt(Q);
    chk(sda_pull == 1'b0, "R6 released after stop", sda_pull, 0);
  endtask

  task automatic drained(input string req);
    wt(8);
    chk(expq.size() == 0, req, expq.size(), 0);
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    fails++;
    $display("FAIL watchdog expired actual=running expected=done");
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

  initial begin
    wt(5);
    chk(sda_pull == 1'b0, "R1 pull at reset", sda_pull, 0);
    chk(vld == 1'b0, "R1 strobe at reset", vld, 0);
    rst_n = 1'b1; wt(5);

    // R2/R3/R5: strap high, address 0x32, three bytes
    strap = 1'b1; wt(5);
    start_c();
    send_byte(8'h32, 1'b1, "R2 R3 ack of 0x32 with strap high");
    foreach (expq[i]) ;
    expq.push_back(8'hA5); send_byte(8'hA5, 1'b1, "R3 ack data 1");
    expq.push_back(8'h00); send_byte(8'h00, 1'b1, "R3 ack data 2");
    expq.push_back(8'hFF); send_byte(8'hFF, 1'b1, "R3 ack data 3");
    stop_c();
    drained("R5 all bytes delivered");

    // R2: strap low, address 0x30
    strap = 1'b0; wt(5);
    start_c();
    send_byte(8'h30, 1'b1, "R2 ack of 0x30 with strap low");
    expq.push_back(8'h3C); send_byte(8'h3C, 1'b1, "R3 ack data strap low");
    stop_c();
    drained("R2 strap low byte delivered");

    // R4: mismatch (0x32 while strap low)
    start_c();
    send_byte(8'h32, 1'b0, "R4 no ack on mismatch");
    send_byte(8'h55, 1'b0, "R4 no ack after mismatch");
    stop_c();
    drained("R4 no strobe after mismatch");

    // R4: read request with strap high
    strap = 1'b1; wt(5);
    start_c();
    send_byte(8'h33, 1'b0, "R4 no ack on read bit");
    send_byte(8'h12, 1'b0, "R4 ignored after read");
    stop_c();
    drained("R4 no strobe after read");

    // R6: bytes after stop without start
    send_byte(8'h32, 1'b0, "R6 no ack without start");
    drained("R6 no strobe without start");

    // R7: repeated start
    start_c();
    send_byte(8'h32, 1'b1, "R7 first address ack");
    expq.push_back(8'h81); send_byte(8'h81, 1'b1, "R7 data before restart");
    start_c();
    send_byte(8'h32, 1'b1, "R7 restart address acked as address");
    expq.push_back(8'h7E); send_byte(8'h7E, 1'b1, "R7 data after restart");
    start_c();
    send_byte(8'h30, 1'b0, "R7 restart with wrong address not acked");
    stop_c();
    drained("R7 bytes delivered");

    // R8: stop partway through a data byte
    start_c();
    send_byte(8'h32, 1'b1, "R8 address ack");
    for (int i = 0; i < 4; i++) bit_clk(1'b1, 1'b0, "R8 partial bit no pull");
    stop_c();
    drained("R8 partial byte discarded");
    start_c();
    send_byte(8'h32, 1'b1, "R8 next transfer address ack");
    expq.push_back(8'hC3); send_byte(8'hC3, 1'b1, "R8 next transfer aligned");
    stop_c();
    drained("R8 next transfer delivered");

    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end
endmodule